// File: doc/BRIEF.md
# Legacy Memory Attribute Router

This block steers memory accesses that fall in the legacy window between 640 KB and 1 MB. Seven byte-wide attribute registers, written through a small configuration port, give every one of thirteen address segments two independent enables: one for reads and one for writes. A segment can therefore be disabled, read-only, write-only or read/write.

On its access-decode port the block takes an address, a read/write flag and the requester type, which is either the host or a PCI initiator. It answers combinationally with three decisions. The first says whether main memory claims the access. The second says whether a host access is sent on to PCI. The third says whether the bridge answers a PCI initiator as a PCI target.

A typical use is shadowing a boot ROM. Software sets a segment to write-only and reads each location, and those reads go to PCI. It writes the same data back, and those writes land in main memory. It then switches the segment to read-only.

Top module: `legacy_attr_router`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) every attribute register reads back 00h, and every access in the window is unclaimed by memory.
- R2: The seven registers sit at cfg_addr 59h..5Fh. A write with cfg_we=1 updates the register at the clock edge. cfg_rdata is a combinational read of the register at cfg_addr, so the new value is seen from the cycle after the write, and so is its effect on access decoding.
- R3: Reserved bits read 0 and ignore writes. At 59h only bits 4 and 5 are stored (mask 30h). At 5Ah..5Fh only bits 0, 1, 4 and 5 are stored (mask 33h).
- R4: A write to any offset outside 59h..5Fh changes no register, and a read there returns 00h.
- R5: Segment map. Bits 5:4 of 59h control F0000h..FFFFFh. For n=0..5, bits 1:0 of offset 5Ah+n control the 16 KB segment at C0000h+n*8000h, and bits 5:4 control the 16 KB segment at C4000h+n*8000h. In each field the lower bit is the read enable and the upper bit is the write enable.
- R6: A read (acc_write=0) to a segment whose read enable is 1 gives mem_claim=1. If that read enable is 0, mem_claim=0, and a host read gives host_to_pci=1.
- R7: A write (acc_write=1) to a segment whose write enable is 1 gives mem_claim=1. If that write enable is 0, mem_claim=0, and a host write gives host_to_pci=1.
- R8: The enables apply equally to PCI initiators (acc_from_pci=1). pci_target=1 exactly when the access comes from PCI and the enable for its direction is 1. A host access never raises pci_target, and a PCI access never raises host_to_pci.
- R9: Addresses in A0000h..BFFFFh, below A0000h or from 100000h up give mem_claim=0, host_to_pci=0 and pci_target=0, whatever the register contents.
- R10: Write-only shadowing. With a segment set to write-only, a host read of an address goes to PCI, and a host write to the same address is claimed by memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data at cfg_addr |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_from_pci | input | 1 | 1 = PCI initiator, 0 = host |
| mem_claim | output | 1 | Access is claimed and directed to main memory |
| host_to_pci | output | 1 | Host access inside a controlled segment is forwarded to PCI |
| pci_target | output | 1 | Bridge responds as PCI target to this PCI-initiated access |

## Verification
A wrong attribute bit is visible in two places. It shows at cfg_rdata in the cycle after the write, and it flips mem_claim together with host_to_pci or pci_target for every address of the one segment it governs. A segment decoded to the wrong field shows as a wrong decision at that segment's first or last byte. A neighbour deliberately holds the opposite mode, so the error cannot stay hidden. Decoding is combinational, so any fault in the address ranges appears in the same cycle the address is presented.

// File: rtl/lma_pkg.sv
// Package: shared constants and helpers for the legacy memory attribute router.
// Assumes one byte per attribute register and two 4-bit fields per byte.
package lma_pkg;
    localparam int BYTE_W   = 8;
    localparam int FIELD_W  = 4;
    localparam int RD_BIT   = 0;   // read-enable position inside a field
    localparam int WR_BIT   = 1;   // write-enable position inside a field

    // Storable bits of a register: the first register keeps only its high field.
    function automatic logic [BYTE_W-1:0] keep_mask(input int idx);
        return (idx == 0) ? 8'h30 : 8'h33;
    endfunction
endpackage

// File: rtl/lma_cfg_regs.sv
// Module: attribute register file. Holds NUM_REGS bytes at consecutive
// offsets from CFG_BASE, masks reserved bits on write, returns zero for
// unmapped offsets. Assumes synchronous active-low reset.
module lma_cfg_regs
    import lma_pkg::*;
#(
    parameter int                NUM_REGS = 7,
    parameter int                CFG_AW   = 8,
    parameter logic [CFG_AW-1:0] CFG_BASE = 8'h59
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [BYTE_W-1:0]            cfg_wdata,
    output logic [BYTE_W-1:0]            cfg_rdata,
    output logic [NUM_REGS*BYTE_W-1:0]   regs_flat
);
    logic [BYTE_W-1:0] regs_q [NUM_REGS];
    logic [NUM_REGS-1:0] sel;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        localparam logic [BYTE_W-1:0] MASK = keep_mask(k);
        localparam logic [CFG_AW-1:0] OFF  = CFG_BASE + CFG_AW'(k);

        assign sel[k] = (cfg_addr == OFF);

        // Purpose: load masked write data into register k, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[k] <= '0;
            else if (cfg_we && sel[k])
                regs_q[k] <= cfg_wdata & MASK;
        end

        assign regs_flat[k*BYTE_W +: BYTE_W] = regs_q[k];

        // R2: a matched write lands, masked, at the next edge (R3 masking)
        a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && sel[k]) |=> (regs_q[k] == ($past(cfg_wdata) & MASK)));

        // R4: without a matched write the register holds its value
        a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && sel[k]) |=> $stable(regs_q[k]));
    end

    // Purpose: combinational read of the selected register, zero when unmapped.
    always_comb begin
        cfg_rdata = '0;
        for (int k = 0; k < NUM_REGS; k++)
            if (sel[k]) cfg_rdata = regs_q[k];
    end

    // Offsets are distinct, so at most one register is selected.
    a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/lma_seg_decode.sv
// Module: segment decoder. Turns an address into a one-hot segment vector.
// Segments 0..NUM_SMALL-1 are consecutive small regions from LOW_BASE,
// and the last segment is the single large region at TOP_BASE. Assumes
// the ranges do not overlap.
module lma_seg_decode #(
    parameter int                ADDR_W      = 32,
    parameter int                NUM_SMALL   = 12,
    parameter logic [ADDR_W-1:0] LOW_BASE    = 'hC0000,
    parameter int                SMALL_SHIFT = 14,
    parameter logic [ADDR_W-1:0] TOP_BASE    = 'hF0000,
    parameter int                TOP_SHIFT   = 16,
    localparam int               NUM_SEGS    = NUM_SMALL + 1
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_SEGS-1:0] seg_hit
);
    localparam int EW = ADDR_W + 1;
    logic [EW-1:0] addr_x;
    assign addr_x = {1'b0, addr};

    for (genvar s = 0; s < NUM_SMALL; s++) begin : g_small
        localparam logic [EW-1:0] LO = EW'(LOW_BASE) + (EW'(s) << SMALL_SHIFT);
        localparam logic [EW-1:0] HI = LO + (EW'(1) << SMALL_SHIFT);
        assign seg_hit[s] = (addr_x >= LO) && (addr_x < HI);
    end

    localparam logic [EW-1:0] TOP_LO = EW'(TOP_BASE);
    localparam logic [EW-1:0] TOP_HI = TOP_LO + (EW'(1) << TOP_SHIFT);
    assign seg_hit[NUM_SEGS-1] = (addr_x >= TOP_LO) && (addr_x < TOP_HI);
endmodule

// File: rtl/lma_attr_select.sv
// Module: attribute selector. Picks the read and write enables of the hit
// segment out of the register bytes. Small segment s uses register 1+s/2,
// field s%2; the large top segment uses register 0, high field.
module lma_attr_select
    import lma_pkg::*;
#(
    parameter int  NUM_REGS = 7,
    localparam int NUM_SEGS = 2 * (NUM_REGS - 1) + 1
) (
    input  logic [NUM_REGS*BYTE_W-1:0] regs_flat,
    input  logic [NUM_SEGS-1:0]        seg_hit,
    output logic                       seg_any,
    output logic                       rd_en,
    output logic                       wr_en
);
    logic [NUM_SEGS-1:0] rd_vec;
    logic [NUM_SEGS-1:0] wr_vec;
    logic unused_bits;

    for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
        localparam int REG = (s == NUM_SEGS - 1) ? 0 : 1 + s / 2;
        localparam int NIB = (s == NUM_SEGS - 1) ? 1 : s % 2;
        localparam int POS = REG * BYTE_W + NIB * FIELD_W;
        assign rd_vec[s] = seg_hit[s] & regs_flat[POS + RD_BIT];
        assign wr_vec[s] = seg_hit[s] & regs_flat[POS + WR_BIT];
    end

    assign seg_any     = |seg_hit;
    assign rd_en       = |rd_vec;
    assign wr_en       = |wr_vec;
    assign unused_bits = ^regs_flat;
endmodule

// File: rtl/legacy_attr_router.sv
// Module: legacy memory attribute router (top). Routes accesses in the
// 640 KB..1 MB window to memory or PCI from per-segment read and write
// enables. Decode is combinational and sees register writes from the next
// cycle on. Assumes synchronous active-low reset.
module legacy_attr_router
    import lma_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                CFG_AW      = 8,
    parameter int                NUM_REGS    = 7,
    parameter logic [CFG_AW-1:0] CFG_BASE    = 8'h59,
    parameter logic [ADDR_W-1:0] LOW_BASE    = 'hC0000,
    parameter int                SMALL_SHIFT = 14,
    parameter logic [ADDR_W-1:0] TOP_BASE    = 'hF0000,
    parameter int                TOP_SHIFT   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_from_pci,
    output logic              mem_claim,
    output logic              host_to_pci,
    output logic              pci_target
);
    localparam int NUM_SMALL = 2 * (NUM_REGS - 1);
    localparam int NUM_SEGS  = NUM_SMALL + 1;

    logic [NUM_REGS*BYTE_W-1:0] regs_flat;
    logic [NUM_SEGS-1:0]        seg_hit;
    logic                       seg_any, rd_en, wr_en, dir_en;

    lma_cfg_regs #(
        .NUM_REGS (NUM_REGS),
        .CFG_AW   (CFG_AW),
        .CFG_BASE (CFG_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .regs_flat (regs_flat)
    );

    lma_seg_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_SMALL   (NUM_SMALL),
        .LOW_BASE    (LOW_BASE),
        .SMALL_SHIFT (SMALL_SHIFT),
        .TOP_BASE    (TOP_BASE),
        .TOP_SHIFT   (TOP_SHIFT)
    ) u_dec (
        .addr    (acc_addr),
        .seg_hit (seg_hit)
    );

    lma_attr_select #(
        .NUM_REGS (NUM_REGS)
    ) u_sel (
        .regs_flat (regs_flat),
        .seg_hit   (seg_hit),
        .seg_any   (seg_any),
        .rd_en     (rd_en),
        .wr_en     (wr_en)
    );

    // Purpose: pick the enable for the access direction and form the decisions.
    always_comb begin
        dir_en      = acc_write ? wr_en : rd_en;
        mem_claim   = dir_en;
        host_to_pci = !acc_from_pci && seg_any && !dir_en;
        pci_target  = acc_from_pci && dir_en;
    end

    // R5: the decoder never reports two segments at once
    a_r5_one_segment: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seg_hit));
    // R9: no decision is produced outside a controlled segment
    a_r9_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_any |-> !(mem_claim || host_to_pci || pci_target));
    // R6: memory and PCI forwarding never both take one access
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_claim && host_to_pci));
    // R8: a target response only for a PCI access that memory claims
    a_r8_target_pci: assert property (@(posedge clk) disable iff (!rst_n)
        pci_target |-> (acc_from_pci && mem_claim));
endmodule

// File: tb/legacy_attr_router_tb.sv
module legacy_attr_router_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [7:0]  cfg_addr = 0;
    logic [7:0]  cfg_wdata = 0;
    logic [7:0]  cfg_rdata;
    logic [31:0] acc_addr = 0;
    logic        acc_write = 0;
    logic        acc_from_pci = 0;
    logic        mem_claim, host_to_pci, pci_target;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [7:0] model [7];

    always #5 clk = ~clk;

    legacy_attr_router u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_from_pci(acc_from_pci),
        .mem_claim(mem_claim), .host_to_pci(host_to_pci), .pci_target(pci_target)
    );

    function automatic logic [7:0] mask_of(int idx);
        return (idx == 0) ? 8'h30 : 8'h33;
    endfunction

    function automatic int seg_of(logic [31:0] a);
        if (a >= 32'hF0000 && a < 32'h100000) return 12;
        if (a >= 32'hC0000 && a < 32'hF0000) return int'((a - 32'hC0000) >> 14);
        return -1;
    endfunction

    function automatic logic [31:0] seg_base(int s);
        return (s == 12) ? 32'hF0000 : 32'hC0000 + 32'(s) * 32'h4000;
    endfunction

    function automatic logic [31:0] seg_size(int s);
        return (s == 12) ? 32'h10000 : 32'h4000;
    endfunction

    function automatic logic [2:0] expect_of(logic [31:0] a, bit wr, bit pci);
        int s; int r; int n; logic [3:0] f; bit en;
        s = seg_of(a);
        if (s < 0) return 3'b000;
        r = (s == 12) ? 0 : 1 + s / 2;
        n = (s == 12) ? 1 : s % 2;
        f = 4'(model[r] >> (4 * n));
        en = wr ? f[1] : f[0];
        return {en, !pci && !en, pci && en};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic cfg_write(logic [7:0] off, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = off; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        if (off >= 8'h59 && off <= 8'h5F)
            model[off - 8'h59] = d & mask_of(int'(off - 8'h59));
    endtask

    task automatic cfg_check(string req, logic [7:0] off, logic [7:0] exp);
        cfg_addr = off;
        #1;
        check(req, 32'(cfg_rdata), 32'(exp), $sformatf("cfg read %h", off));
    endtask

    task automatic acc_check(string req, logic [31:0] a, bit wr, bit pci);
        acc_addr = a; acc_write = wr; acc_from_pci = pci;
        #1;
        check(req, 32'({mem_claim, host_to_pci, pci_target}),
              32'(expect_of(a, wr, pci)),
              $sformatf("addr %h wr=%0d pci=%0d", a, wr, pci));
    endtask

    initial begin
        for (int i = 0; i < 7; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state of registers and decisions
        for (int i = 0; i < 7; i++) cfg_check("R1", 8'(8'h59 + i), 8'h00);
        acc_check("R1", 32'hC0000, 0, 0);
        acc_check("R1", 32'hF8000, 1, 1);

        // R2 / R3: write all ones, reserved bits masked; visible the next cycle
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            cfg_we = 1; cfg_addr = 8'(8'h59 + i); cfg_wdata = 8'hFF;
            #1;
            check("R2", 32'(cfg_rdata), 32'(model[i]), "value before edge");
            @(negedge clk);
            cfg_we = 0;
            model[i] = 8'hFF & mask_of(i);
            cfg_check("R3", 8'(8'h59 + i), model[i]);
        end
        for (int i = 0; i < 7; i++) begin
            cfg_write(8'(8'h59 + i), 8'(8'hA5 ^ (i * 8'h11)));
            cfg_check("R2", 8'(8'h59 + i), model[i]);
        end

        // R4: unmapped offsets neither store nor return data
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_write(8'h00, 8'hFF);
        cfg_write(8'hFF, 8'hFF);
        cfg_check("R4", 8'h58, 8'h00);
        cfg_check("R4", 8'h60, 8'h00);
        for (int i = 0; i < 7; i++) cfg_check("R4", 8'(8'h59 + i), model[i]);

        // R5..R8: each segment in each mode, neighbours in the opposite mode
        for (int s = 0; s < 13; s++) begin
            for (int m = 0; m < 4; m++) begin
                int r; int n; logic [7:0] d;
                r = (s == 12) ? 0 : 1 + s / 2;
                n = (s == 12) ? 1 : s % 2;
                d = (n == 1) ? 8'((m << 4) | (3 - m)) : 8'(((3 - m) << 4) | m);
                cfg_write(8'(8'h59 + r), d);
                for (int c = 0; c < 4; c++) begin
                    string rq;
                    rq = (c >= 2) ? "R8" : ((c % 2) == 1 ? "R7" : "R6");
                    acc_check("R5", seg_base(s), bit'(c % 2), bit'(c / 2));
                    acc_check("R5", seg_base(s) + seg_size(s) - 1, bit'(c % 2), bit'(c / 2));
                    acc_check(rq, seg_base(s) + seg_size(s) / 2 + 32'h123, bit'(c % 2), bit'(c / 2));
                end
            end
        end

        // R9: outside the controlled segments, everything enabled
        for (int i = 0; i < 7; i++) cfg_write(8'(8'h59 + i), 8'h33);
        for (int c = 0; c < 4; c++) begin
            acc_check("R9", 32'h0, bit'(c % 2), bit'(c / 2));
            acc_check("R9", 32'h9FFFF, bit'(c % 2), bit'(c / 2));
            acc_check("R9", 32'hA0000, bit'(c % 2), bit'(c / 2));
            acc_check("R9", 32'hBFFFF, bit'(c % 2), bit'(c / 2));
            acc_check("R9", 32'h100000, bit'(c % 2), bit'(c / 2));
            acc_check("R9", 32'hFFFFFFFF, bit'(c % 2), bit'(c / 2));
        end

        // R5: full window sweep at 4 KB steps under a mixed configuration
        for (int i = 0; i < 7; i++) cfg_write(8'(8'h59 + i), 8'(8'h1D * (i + 3)));
        for (int a = 32'h9F000; a < 32'h101000; a += 32'h1000)
            for (int c = 0; c < 4; c++)
                acc_check("R5", 32'(a), bit'(c % 2), bit'(c / 2));

        // R10: write-only shadowing of the top segment, then of a small one
        cfg_write(8'h59, 8'h20);
        acc_check("R10", 32'hF1234, 0, 0);
        check("R10", 32'(host_to_pci), 32'd1, "shadow read goes to PCI");
        acc_check("R10", 32'hF1234, 1, 0);
        check("R10", 32'(mem_claim), 32'd1, "shadow write to memory");
        cfg_write(8'h5B, 8'h02);
        acc_check("R10", 32'hC8010, 0, 0);
        acc_check("R10", 32'hC8010, 1, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule